// File: doc/BRIEF.md
# Shared Flash Pump Ownership Semaphore

Two processor cores each have a flash bank of their own. Both banks draw on one charge pump, and the flash clock-control settings are shared as well. This block decides which core holds the pump at any moment. Each core has strobes to request ownership, to release it, and to clear its error flag. Each core reads back whether it owns the pump, whether its bank is busy, and whether it has a sticky error. A single owner flag gates both pump use and writes to the clock-control register.

A program or erase command is accepted only when three conditions hold: it targets the issuing core's own bank, the issuing core holds the pump, and that bank is idle. The block then counts out the operation's duration and keeps the pump enabled for that time. A rejected command sets the issuing core's error flag. Ownership goes to core A (index 0) at reset. Core B (index 1) must request the pump and wait for the grant before it can program its bank.

Top module: `pump_sem`

## Requirements
- R1: At most one bit of `own_o` is set in any cycle.
- R2: After reset `own_o` is 2'b01 (core A owns), `busy_o` and `err_o` are zero, `pump_en_o` is low and `clk_cfg_o` equals `CLK_RST`.
- R3: A request from a core that does not own the pump stays pending while the other core holds it. The edge that accepts a release leaves `own_o` zero, and the pending core is granted on the following edge.
- R4: Only the owner can release. A release strobe from a non-owner, or a request strobe from the owner, changes nothing.
- R5: A release is refused while the owner's bank is busy, and also in the cycle in which the owner's command is accepted. A busy bank always belongs to the current owner.
- R6: A command is accepted only if the issuing core owns the pump, `cmd_bank_i` equals the core's index, and its bank is idle. Op 0 (program) keeps `busy_o` high for `PROG_CYC` cycles and op 1 (erase) for `ERASE_CYC` cycles, counted from the accepting edge.
- R7: Any command that is not accepted sets that core's `err_o` bit. The bit stays set until `err_clr_i` is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R8: A clock-control write updates `clk_cfg_o` at the next edge only if the writing core owns the pump. Writes from a non-owner have no effect.
- R9: If both cores request while the pump is free, core A is granted. Core B stays pending and is granted after core A releases.
- R10: `pump_en_o` is high exactly while at least one `busy_o` bit is high.
- R11: A request made while the pump is free is granted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CORES | Per-core ownership request strobe |
| rel_i | input | NUM_CORES | Per-core release strobe |
| cmd_i | input | NUM_CORES | Per-core program/erase command strobe |
| cmd_op_i | input | NUM_CORES | Per-core operation: 0 program, 1 erase |
| cmd_bank_i | input | NUM_CORES*BANK_W | Per-core target bank index, core c in slice c |
| err_clr_i | input | NUM_CORES | Per-core error flag clear strobe |
| clk_wr_i | input | NUM_CORES | Per-core clock-control write strobe |
| clk_wdata_i | input | NUM_CORES*CLK_W | Per-core clock-control write data |
| own_o | output | NUM_CORES | Pump ownership, one bit per core |
| busy_o | output | NUM_CORES | Bank operation in progress, one bit per bank |
| err_o | output | NUM_CORES | Sticky rejected-command flag per core |
| clk_cfg_o | output | CLK_W | Current clock-control setting |
| pump_en_o | output | 1 | Pump enabled for an operation |

## Verification
The conflicts of interest are a release and a command from the owner in the same cycle, a release together with a pending request from the other core, and an error set and clear in the same cycle. The bench provokes these directly. It strobes release together with an accepted command, releases while the other core is pending and watches `own_o` go empty and then flip, and pairs a rejected command with a clear. It then runs long random stretches in which these pairs recur. A behavioural model predicts every output on every clock, and each output is judged against that prediction.

// File: rtl/pump_sem_pkg.sv
package pump_sem_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } flash_op_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/pump_sem_arb.sv
module pump_sem_arb #(
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] req_i,
  input  logic [NUM_CORES-1:0] rel_i,
  input  logic [NUM_CORES-1:0] hold_i,
  output logic [NUM_CORES-1:0] own_o
);
  logic [NUM_CORES-1:0] own_q, own_d;
  logic [NUM_CORES-1:0] pend_q, pend_d;
  logic [NUM_CORES-1:0] want, grant;
  logic                 rel_ok;

  always_comb begin
    want  = (pend_q | req_i) & ~own_q;
    grant = '0;
    // scan downward so the lowest index is assigned last and wins
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (want[c]) begin
        grant    = '0;
        grant[c] = 1'b1;
      end
    end
    rel_ok = |(rel_i & own_q & ~hold_i);
    if (own_q == '0) begin
      own_d  = grant;
      pend_d = want & ~grant;
    end else begin
      own_d  = rel_ok ? '0 : own_q;
      pend_d = want;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= NUM_CORES'(1);
      pend_q <= '0;
    end else begin
      own_q  <= own_d;
      pend_q <= pend_d;
    end
  end

  assign own_o = own_q;
endmodule

// File: rtl/bank_op_ctrl.sv
module bank_op_ctrl
  import pump_sem_pkg::*;
#(
  parameter int CORE_ID   = 0,
  parameter int BANK_W    = 1,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_i,
  input  flash_op_e         op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              own_i,
  input  logic              err_clr_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              start_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = cnt_width(MAX_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             idle;

  assign idle    = (cnt_q == '0);
  assign start_o = cmd_i & own_i & (bank_i == BANK_W'(CORE_ID)) & idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (start_o)
        cnt_q <= (op_i == OP_ERASE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      else if (!idle)
        cnt_q <= cnt_q - 1'b1;
      if (cmd_i && !start_o)
        err_q <= 1'b1;
      else if (err_clr_i)
        err_q <= 1'b0;
    end
  end

  assign busy_o = !idle;
  assign err_o  = err_q;
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg #(
  parameter int                 NUM_CORES = 2,
  parameter int                 CLK_W     = 8,
  parameter logic [CLK_W-1:0]   CLK_RST   = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CORES-1:0]         wr_i,
  input  logic [NUM_CORES*CLK_W-1:0]   wdata_i,
  input  logic [NUM_CORES-1:0]         own_i,
  output logic [CLK_W-1:0]             cfg_o
);
  logic [CLK_W-1:0] cfg_q, cfg_d;
  logic             hit;

  always_comb begin
    cfg_d = cfg_q;
    hit   = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (!hit && wr_i[c] && own_i[c]) begin
        cfg_d = wdata_i[c*CLK_W +: CLK_W];
        hit   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CLK_RST;
    else     cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pump_sem.sv
module pump_sem
  import pump_sem_pkg::*;
#(
  parameter int               NUM_CORES = 2,
  parameter int               PROG_CYC  = 4,
  parameter int               ERASE_CYC = 12,
  parameter int               CLK_W     = 8,
  parameter logic [CLK_W-1:0] CLK_RST   = 8'h01,
  localparam int              BANK_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CORES-1:0]          req_i,
  input  logic [NUM_CORES-1:0]          rel_i,
  input  logic [NUM_CORES-1:0]          cmd_i,
  input  logic [NUM_CORES-1:0]          cmd_op_i,
  input  logic [NUM_CORES*BANK_W-1:0]   cmd_bank_i,
  input  logic [NUM_CORES-1:0]          err_clr_i,
  input  logic [NUM_CORES-1:0]          clk_wr_i,
  input  logic [NUM_CORES*CLK_W-1:0]    clk_wdata_i,
  output logic [NUM_CORES-1:0]          own_o,
  output logic [NUM_CORES-1:0]          busy_o,
  output logic [NUM_CORES-1:0]          err_o,
  output logic [CLK_W-1:0]              clk_cfg_o,
  output logic                          pump_en_o
);
  logic [NUM_CORES-1:0] own, busy, start, hold;

  pump_sem_arb #(.NUM_CORES(NUM_CORES)) u_arb (
    .clk(clk), .rst(rst), .req_i(req_i), .rel_i(rel_i),
    .hold_i(hold), .own_o(own)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
    bank_op_ctrl #(
      .CORE_ID(c), .BANK_W(BANK_W),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_bank (
      .clk(clk), .rst(rst),
      .cmd_i(cmd_i[c]),
      .op_i(flash_op_e'(cmd_op_i[c])),
      .bank_i(cmd_bank_i[c*BANK_W +: BANK_W]),
      .own_i(own[c]),
      .err_clr_i(err_clr_i[c]),
      .busy_o(busy[c]),
      .err_o(err_o[c]),
      .start_o(start[c])
    );
  end

  assign hold = busy | start;

  clkctl_reg #(.NUM_CORES(NUM_CORES), .CLK_W(CLK_W), .CLK_RST(CLK_RST)) u_clk (
    .clk(clk), .rst(rst), .wr_i(clk_wr_i), .wdata_i(clk_wdata_i),
    .own_i(own), .cfg_o(clk_cfg_o)
  );

  assign own_o     = own;
  assign busy_o    = busy;
  assign pump_en_o = |busy;
endmodule

// File: rtl/pump_sem_chk.sv
module pump_sem_chk #(
  parameter int NUM_CORES = 2,
  parameter int CLK_W     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CORES-1:0] rel_i,
  input logic [NUM_CORES-1:0] clk_wr_i,
  input logic [NUM_CORES-1:0] err_clr_i,
  input logic [NUM_CORES-1:0] own_o,
  input logic [NUM_CORES-1:0] busy_o,
  input logic [NUM_CORES-1:0] err_o,
  input logic [CLK_W-1:0]     clk_cfg_o
);
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(own_o)); // R1

  AST_RESET_OWNER: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (own_o == NUM_CORES'(1)) && (busy_o == '0) && (err_o == '0)); // R2

  AST_NO_STEAL: assert property (@(posedge clk) disable iff (rst)
    (|own_o) && !(|(rel_i & own_o)) |=> own_o == $past(own_o)); // R4

  AST_BUSY_IS_OWNER: assert property (@(posedge clk) disable iff (rst)
    (busy_o & ~own_o) == '0); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(err_o & ~err_clr_i)) |=>
      ((err_o & $past(err_o & ~err_clr_i)) == $past(err_o & ~err_clr_i))); // R7

  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(|(clk_wr_i & own_o)) |=> $stable(clk_cfg_o)); // R8
endmodule

bind pump_sem pump_sem_chk #(.NUM_CORES(NUM_CORES), .CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst(rst), .rel_i(rel_i), .clk_wr_i(clk_wr_i),
  .err_clr_i(err_clr_i), .own_o(own_o), .busy_o(busy_o),
  .err_o(err_o), .clk_cfg_o(clk_cfg_o)
);

// File: tb/pump_sem_test.sv
module pump_sem_test;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 2;
  localparam int PC  = 4;
  localparam int EC  = 12;
  localparam int CW  = 8;
  localparam logic [CW-1:0] CRST = 8'h01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_i = '0, rel_i = '0, cmd_i = '0, cmd_op_i = '0;
  logic [N-1:0] cmd_bank_i = '0, err_clr_i = '0, clk_wr_i = '0;
  logic [N*CW-1:0] clk_wdata_i = '0;
  logic [N-1:0] own_o, busy_o, err_o;
  logic [CW-1:0] clk_cfg_o;
  logic pump_en_o;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // behavioural reference state
  int m_own;
  int m_pend[N];
  int m_cnt[N];
  int m_err[N];
  int m_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  pump_sem #(.NUM_CORES(N), .PROG_CYC(PC), .ERASE_CYC(EC), .CLK_W(CW), .CLK_RST(CRST)) uut (
    .clk(clk), .rst(rst), .req_i(req_i), .rel_i(rel_i), .cmd_i(cmd_i),
    .cmd_op_i(cmd_op_i), .cmd_bank_i(cmd_bank_i), .err_clr_i(err_clr_i),
    .clk_wr_i(clk_wr_i), .clk_wdata_i(clk_wdata_i), .own_o(own_o),
    .busy_o(busy_o), .err_o(err_o), .clk_cfg_o(clk_cfg_o), .pump_en_o(pump_en_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int st[N];
    int nown;
    int anyb;
    cycles++;
    if (rst) begin
      m_own = 0; m_clk = int'(CRST);
      for (int c = 0; c < N; c++) begin m_pend[c] = 0; m_cnt[c] = 0; m_err[c] = 0; end
    end else begin
      for (int c = 0; c < N; c++)
        st[c] = (cmd_i[c] && m_own == c && int'(cmd_bank_i[c]) == c && m_cnt[c] == 0) ? 1 : 0;
      if (m_own >= 0 && clk_wr_i[m_own]) m_clk = int'(clk_wdata_i[m_own*CW +: CW]);
      nown = m_own;
      if (m_own < 0) begin
        for (int c = N - 1; c >= 0; c--)
          if (m_pend[c] != 0 || req_i[c]) nown = c;
        for (int c = 0; c < N; c++)
          m_pend[c] = ((m_pend[c] != 0 || req_i[c]) && c != nown) ? 1 : 0;
      end else begin
        for (int c = 0; c < N; c++)
          m_pend[c] = ((m_pend[c] != 0 || req_i[c]) && c != m_own) ? 1 : 0;
        if (rel_i[m_own] && m_cnt[m_own] == 0 && st[m_own] == 0) nown = -1;
      end
      m_own = nown;
      for (int c = 0; c < N; c++) begin
        if (st[c] != 0) m_cnt[c] = cmd_op_i[c] ? EC : PC;
        else if (m_cnt[c] > 0) m_cnt[c]--;
        if (cmd_i[c] && st[c] == 0) m_err[c] = 1;
        else if (err_clr_i[c]) m_err[c] = 0;
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // model compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int eo, eb, ee, anyb;
      eo = 0; eb = 0; ee = 0; anyb = 0;
      if (m_own >= 0) eo = 1 << m_own;
      for (int c = 0; c < N; c++) begin
        if (m_cnt[c] > 0) begin eb |= 1 << c; anyb = 1; end
        if (m_err[c] != 0) ee |= 1 << c;
      end
      check("R1/R3/R9 model own", int'(own_o), eo);
      check("R6 model busy", int'(busy_o), eb);
      check("R7 model err", int'(err_o), ee);
      check("R8 model clk_cfg", int'(clk_cfg_o), m_clk);
      check("R10 model pump_en", int'(pump_en_o), anyb);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    req_i = '0; rel_i = '0; cmd_i = '0; cmd_op_i = '0; cmd_bank_i = '0;
    err_clr_i = '0; clk_wr_i = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R2 reset own", int'(own_o), 1);
    check("R2 reset busy", int'(busy_o), 0);
    check("R2 reset err", int'(err_o), 0);
    check("R2 reset clk", int'(clk_cfg_o), int'(CRST));
    check("R2 reset pump", int'(pump_en_o), 0);

    req_i[1] = 1'b1; tick();
    check("R3 pending not granted", int'(own_o), 1);
    req_i[0] = 1'b1; tick();
    check("R4 owner request no effect", int'(own_o), 1);

    cmd_i[0] = 1'b1; cmd_bank_i[0] = 1'b1; tick();
    check("R6 foreign bank rejected", int'(busy_o), 0);
    check("R7 err set", int'(err_o), 1);
    err_clr_i[0] = 1'b1; tick();
    check("R7 err cleared", int'(err_o), 0);

    cmd_i[0] = 1'b1; rel_i[0] = 1'b1; tick();
    check("R5 release with accepted command refused", int'(own_o), 1);
    check("R6 program busy", int'(busy_o), 1);
    check("R10 pump on", int'(pump_en_o), 1);
    rel_i[0] = 1'b1; tick();
    check("R5 release while busy refused", int'(own_o), 1);
    rel_i[1] = 1'b1; clk_wr_i[1] = 1'b1; clk_wdata_i[CW +: CW] = 8'h55; tick();
    check("R4 non-owner release ignored", int'(own_o), 1);
    check("R8 non-owner clk write ignored", int'(clk_cfg_o), int'(CRST));
    clk_wr_i[0] = 1'b1; clk_wdata_i[0 +: CW] = 8'h33; tick();
    check("R8 owner clk write", int'(clk_cfg_o), 8'h33);
    check("R6 program still busy on last cycle", int'(busy_o), 1);
    tick();
    check("R6 program length", int'(busy_o), 0);
    check("R10 pump off", int'(pump_en_o), 0);

    rel_i[0] = 1'b1; tick();
    check("R3 free after release", int'(own_o), 0);
    tick();
    check("R3 grant next cycle", int'(own_o), 2);

    cmd_i = 2'b11; cmd_bank_i = 2'b00; tick();
    check("R6 non-owner and foreign bank rejected", int'(err_o), 3);
    err_clr_i = 2'b11; tick();
    cmd_i[1] = 1'b1; cmd_op_i[1] = 1'b1; cmd_bank_i[1] = 1'b1; tick();
    repeat (EC - 1) tick();
    check("R6 erase still busy", int'(busy_o), 2);
    tick();
    check("R6 erase length", int'(busy_o), 0);

    rel_i[1] = 1'b1; tick();
    check("R4 owner release frees", int'(own_o), 0);
    req_i = 2'b11; tick();
    check("R9 core A wins tie", int'(own_o), 1);
    check("R11 grant while free", int'(own_o), 1);
    rel_i[0] = 1'b1; tick();
    check("R9 free after A release", int'(own_o), 0);
    tick();
    check("R9 B granted later", int'(own_o), 2);

    cmd_i[0] = 1'b1; err_clr_i[0] = 1'b1; tick();
    check("R7 set wins over clear", int'(err_o), 1);

    for (int i = 0; i < 4000; i++) begin
      req_i       = N'($urandom_range(0, 3) & (($urandom_range(0, 3) == 0) ? 3 : 0));
      rel_i       = N'($urandom_range(0, 3) & (($urandom_range(0, 2) == 0) ? 3 : 0));
      cmd_i       = N'($urandom_range(0, 3) & (($urandom_range(0, 3) == 0) ? 3 : 0));
      cmd_op_i    = N'($urandom_range(0, 3));
      cmd_bank_i  = N'($urandom_range(0, 3));
      err_clr_i   = N'($urandom_range(0, 3) & (($urandom_range(0, 4) == 0) ? 3 : 0));
      clk_wr_i    = N'($urandom_range(0, 3) & (($urandom_range(0, 3) == 0) ? 3 : 0));
      clk_wdata_i = (N*CW)'($urandom());
      tick();
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule